// File: doc/BRIEF.md
# Octant-Folded Arctangent Phase Calculator

This block turns a pair of signed correlator sums into a phase angle. One sum is the in-phase (cosine-weighted) total and the other the quadrature (sine-weighted) total. The result is the four-quadrant angle of the vector (cosine sum, sine sum). The block first compares the two magnitudes. The smaller one is divided by the larger one, so the ratio always lies in [0, 1). That ratio only needs an arctangent over the first octant, 0° to 45°. The octant result is then placed in the full turn using the two signs and the outcome of the magnitude comparison.

A caller presents both sums with a one-cycle start strobe while the block is idle. A restoring divider builds a 12-bit fractional ratio, one quotient bit per clock. A single lookup cycle follows. The phase then appears as a 12-bit fraction of a full turn, together with a one-cycle valid pulse. Very small ratios skip the table and use the scaled ratio itself, because arctan(x) ≈ x there. A vector with both sums zero has no defined angle and is flagged instead.

Top module: `phase_octant_calc`

## Requirements
- R1: After reset and until the first result, busy, valid and the undefined flag are low and the phase output is 0.
- R2: A start seen while idle is accepted and busy goes high from the next cycle. For a non-zero vector, valid rises on the 14th rising edge, counting the edge that sampled start as the first (12 divide steps plus one lookup).
- R3: A start strobe that arrives while busy is ignored: the pending result still belongs to the first operands and arrives with the first operands' timing.
- R4: When both sums are zero, valid rises on the 2nd rising edge with phase 0 and the undefined flag set. Any non-zero result clears that flag.
- R5: The phase is unsigned, 12 bits, with 4096 equal to 360°. It matches atan2(sine sum, cosine sum), wrapped to [0, 4096), within 3 LSB. A zero sum counts as non-negative.
- R6: When |cos| ≥ |sin|, with base angle b = arctan(|sin|/|cos|): both non-negative gives b; cos ≥ 0 and sin < 0 gives 4096 − b; cos < 0 and sin ≥ 0 gives 2048 − b; both negative gives 2048 + b.
- R7: When |cos| < |sin|, with b = arctan(|cos|/|sin|): both non-negative gives 1024 − b; cos ≥ 0 and sin < 0 gives 3072 + b; cos < 0 and sin ≥ 0 gives 1024 + b; both negative gives 3072 − b.
- R8: The ratio is a 12-bit fraction from a restoring divider. Equal magnitudes give 4095/4096, so the base angle stays at or below 512 (45°).
- R9: For a ratio below 1/32, the base angle is round(ratio × 163 / 1024), in ratio units of 1/4096. This is within 1 LSB of the true arctangent. Larger ratios use a 256-entry first-octant table indexed by the top 8 ratio bits.
- R10: Vectors on an axis give exactly 0, 1024, 2048 or 3072.
- R11: Valid is high for exactly one cycle per result. Phase and the undefined flag hold their values until the next result.
- R12: The most negative sum value (−2^(SUM_W−1)) is handled, including when both sums take it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request; sampled only while idle |
| dc_cos_i | input | SUM_W | Signed cosine-weighted correlator sum |
| dc_sin_i | input | SUM_W | Signed sine-weighted correlator sum |
| busy_o | output | 1 | High from acceptance until the result cycle |
| phase_valid_o | output | 1 | One-cycle pulse marking a new result |
| phase_o | output | 12 | Phase as a fraction of a turn (4096 = 360°) |
| undef_o | output | 1 | Result is undefined because both sums were zero |

## Verification
A corrupted capture of a sign or of the swap decision shows up as a phase in the wrong octant. The error is a multiple of 512 LSB or a reflection about an octant edge, visible on the very result that follows the bad capture. A divider fault, such as a miscounted step or a wrong restore, shows as a latency other than 14 edges or a base angle off by many LSB within the same request. A fault in the table or the small-ratio path only moves the answer by a few LSB inside the octant. For that reason the directed cases sit close to the octant edges, on the axes and below the 1/32 threshold, where the tolerance is tight.

// File: rtl/phase_calc_pkg.sv
package phase_calc_pkg;

  // Output angle: 2^PHASE_W units per full turn
  localparam int PHASE_W   = 12;
  // Fractional bits of the min/max ratio
  localparam int RATIO_W   = 12;
  // Table index bits taken from the top of the ratio
  localparam int LUT_AW    = 8;
  localparam int LUT_N     = 1 << LUT_AW;
  // Ratios below 2^-SMALL_LOG use the linear approximation
  localparam int SMALL_LOG = 5;
  // Linear slope: 2^PHASE_W / (2*pi) / 2^RATIO_W ~= SLOPE_NUM / 2^SLOPE_SH
  localparam int SLOPE_NUM = 163;
  localparam int SLOPE_SH  = 10;
  // Angle iteration used at elaboration to fill the table
  localparam int CORDIC_N  = 14;
  localparam int ANG_FRAC  = 8;

  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    logic neg_c;
    logic neg_s;
    logic swap;
    logic zero;
  } fold_t;

  // atan(2^-k) in units of 2^(PHASE_W+ANG_FRAC) per turn
  function automatic longint step_angle(input int k);
    case (k)
      0:  return 64'sd131072;
      1:  return 64'sd77376;
      2:  return 64'sd40884;
      3:  return 64'sd20753;
      4:  return 64'sd10417;
      5:  return 64'sd5213;
      6:  return 64'sd2607;
      7:  return 64'sd1304;
      8:  return 64'sd652;
      9:  return 64'sd326;
      10: return 64'sd163;
      11: return 64'sd81;
      12: return 64'sd41;
      default: return 64'sd20;
    endcase
  endfunction

  // arctan(num / 2^RATIO_W) in phase units, by vectoring iterations
  function automatic phase_t octant_atan(input int unsigned num);
    longint x;
    longint y;
    longint z;
    longint xn;
    x = longint'(1) << (RATIO_W + 12);
    y = longint'(num) << 12;
    z = 0;
    for (int k = 0; k < CORDIC_N; k++) begin
      if (y >= 0) begin
        xn = x + (y >>> k);
        y  = y - (x >>> k);
        z  = z + step_angle(k);
      end else begin
        xn = x - (y >>> k);
        y  = y + (x >>> k);
        z  = z - step_angle(k);
      end
      x = xn;
    end
    return phase_t'((z + (longint'(1) << (ANG_FRAC - 1))) >>> ANG_FRAC);
  endfunction

  // Small-ratio path: arctan(r) ~= r, rescaled to phase units
  function automatic phase_t small_atan(input ratio_t r);
    int t;
    t = int'(r) * SLOPE_NUM + (1 << (SLOPE_SH - 1));
    return phase_t'(t >>> SLOPE_SH);
  endfunction

  // Place a first-octant angle into the full turn
  function automatic phase_t fold_octant(input phase_t base, input logic swap,
                                         input logic neg_c, input logic neg_s);
    phase_t qtr;
    phase_t half;
    phase_t tqtr;
    phase_t res;
    qtr  = phase_t'(1 << (PHASE_W - 2));
    half = phase_t'(1 << (PHASE_W - 1));
    tqtr = phase_t'(3 << (PHASE_W - 2));
    unique case ({swap, neg_c, neg_s})
      3'b000:  res = base;
      3'b001:  res = phase_t'(0) - base;
      3'b010:  res = half - base;
      3'b011:  res = half + base;
      3'b100:  res = qtr - base;
      3'b101:  res = tqtr + base;
      3'b110:  res = qtr + base;
      default: res = tqtr - base;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/phase_ratio_div.sv
module phase_ratio_div
  import phase_calc_pkg::*;
#(
  parameter int MAG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [MAG_W-1:0] num_i,
  input  logic [MAG_W-1:0] den_i,
  output ratio_t           quot_o,
  output logic             last_o,
  output logic             run_o
);

  localparam int CNT_W = $clog2(RATIO_W + 1);

  logic [MAG_W-1:0] rem_q;
  logic [MAG_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  ratio_t           quot_q;

  logic [MAG_W:0]   rem_sh;
  logic [MAG_W:0]   rem_dif;
  logic             fits;

  // One restoring step: shift, trial-subtract, keep on success
  assign rem_sh  = {rem_q, 1'b0};
  assign fits    = rem_sh >= {1'b0, den_q};
  assign rem_dif = rem_sh - {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      quot_q <= '0;
    end else if (load_i) begin
      rem_q  <= num_i;
      den_q  <= den_i;
      cnt_q  <= CNT_W'(RATIO_W);
      run_q  <= 1'b1;
      quot_q <= '0;
    end else if (run_q) begin
      rem_q  <= fits ? rem_dif[MAG_W-1:0] : rem_sh[MAG_W-1:0];
      quot_q <= {quot_q[RATIO_W-2:0], fits};
      cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
    end
  end

  assign quot_o = quot_q;
  assign last_o = run_q && (cnt_q == CNT_W'(1));
  assign run_o  = run_q;

endmodule

// File: rtl/phase_atan_lut.sv
module phase_atan_lut
  import phase_calc_pkg::*;
(
  input  ratio_t ratio_i,
  output phase_t base_o,
  output logic   small_o
);

  localparam int IDX_SH    = RATIO_W - LUT_AW;
  localparam int SMALL_LIM = 1 << (RATIO_W - SMALL_LOG);

  phase_t table_w [LUT_N];

  // Each entry is the arctangent at the middle of its ratio bin
  for (genvar i = 0; i < LUT_N; i++) begin : g_rom
    localparam int unsigned MID   = (i << IDX_SH) + (1 << (IDX_SH - 1));
    localparam phase_t      ENTRY = octant_atan(MID);
    assign table_w[i] = ENTRY;
  end

  logic [LUT_AW-1:0] idx;
  assign idx     = ratio_i[RATIO_W-1 -: LUT_AW];
  assign small_o = ratio_i < ratio_t'(SMALL_LIM);
  assign base_o  = small_o ? small_atan(ratio_i) : table_w[idx];

endmodule

// File: rtl/phase_octant_fold.sv
module phase_octant_fold
  import phase_calc_pkg::*;
(
  input  phase_t base_i,
  input  logic   swap_i,
  input  logic   neg_c_i,
  input  logic   neg_s_i,
  output phase_t phase_o
);

  assign phase_o = fold_octant(base_i, swap_i, neg_c_i, neg_s_i);

endmodule

// File: rtl/phase_octant_calc.sv
module phase_octant_calc
  import phase_calc_pkg::*;
#(
  parameter int SUM_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic signed [SUM_W-1:0] dc_cos_i,
  input  logic signed [SUM_W-1:0] dc_sin_i,
  output logic                    busy_o,
  output logic                    phase_valid_o,
  output logic [PHASE_W-1:0]      phase_o,
  output logic                    undef_o
);

  localparam int MAG_W = SUM_W;

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_MAP} state_e;

  function automatic logic [MAG_W-1:0] mag_of(input logic signed [SUM_W-1:0] v);
    return v[SUM_W-1] ? MAG_W'(-v) : MAG_W'(v);
  endfunction

  state_e           state_q;
  fold_t            fold_q;
  phase_t           phase_q;
  logic             valid_q;
  logic             undef_q;

  logic [MAG_W-1:0] mag_c;
  logic [MAG_W-1:0] mag_s;
  logic             in_swap;
  logic             in_zero;

  // Named events shared with the checker
  logic             accept;
  logic             div_load;
  logic             div_last;
  logic             div_run;
  logic             map_en;
  logic             small_sel;
  ratio_t           ratio;
  phase_t           base_angle;
  phase_t           folded;

  assign mag_c    = mag_of(dc_cos_i);
  assign mag_s    = mag_of(dc_sin_i);
  assign in_swap  = mag_c < mag_s;
  assign in_zero  = (mag_c == '0) && (mag_s == '0);

  assign accept   = start_i && (state_q == ST_IDLE);
  assign div_load = accept && !in_zero;
  assign map_en   = state_q == ST_MAP;

  phase_ratio_div #(.MAG_W(MAG_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (div_load),
    .num_i  (in_swap ? mag_c : mag_s),
    .den_i  (in_swap ? mag_s : mag_c),
    .quot_o (ratio),
    .last_o (div_last),
    .run_o  (div_run)
  );

  phase_atan_lut u_lut (
    .ratio_i (ratio),
    .base_o  (base_angle),
    .small_o (small_sel)
  );

  phase_octant_fold u_fold (
    .base_i  (base_angle),
    .swap_i  (fold_q.swap),
    .neg_c_i (fold_q.neg_c),
    .neg_s_i (fold_q.neg_s),
    .phase_o (folded)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fold_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          fold_q  <= '{neg_c: dc_cos_i[SUM_W-1], neg_s: dc_sin_i[SUM_W-1],
                       swap: in_swap, zero: in_zero};
          state_q <= in_zero ? ST_MAP : ST_DIV;
        end
        ST_DIV:  if (div_last) state_q <= ST_MAP;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      valid_q <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      valid_q <= map_en;
      if (map_en) begin
        phase_q <= fold_q.zero ? phase_t'(0) : folded;
        undef_q <= fold_q.zero;
      end
    end
  end

  assign busy_o        = state_q != ST_IDLE;
  assign phase_valid_o = valid_q;
  assign phase_o       = phase_q;
  assign undef_o       = undef_q;

endmodule

// File: rtl/phase_calc_checker.sv
module phase_calc_checker
  import phase_calc_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   start_i,
  input logic   busy_o,
  input logic   phase_valid_o,
  input logic   undef_o,
  input phase_t phase_o,
  input logic   accept,
  input logic   map_en,
  input logic   small_sel,
  input phase_t base_angle
);

  localparam int LAT_W     = $clog2(RATIO_W + 3);
  localparam int OCT_MAX   = 1 << (PHASE_W - 3);
  localparam int SMALL_MAX = ((1 << (RATIO_W - SMALL_LOG)) * SLOPE_NUM
                              + (1 << (SLOPE_SH - 1))) >> SLOPE_SH;

  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                lat_q <= '0;
    else if (start_i && !busy_o) lat_q <= LAT_W'(1);
    else if (busy_o)           lat_q <= lat_q + 1'b1;
  end

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_valid_o && !undef_o) |-> (lat_q == LAT_W'(RATIO_W + 2)));

  assert_zero_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_valid_o && undef_o) |-> (lat_q == LAT_W'(2) && phase_o == '0));

  assert_ignore_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || phase_valid_o));

  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid_o |=> !phase_valid_o);

  assert_hold_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_valid_o |-> ($stable(phase_o) && $stable(undef_o)));

  assert_octant_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    map_en |-> (base_angle <= phase_t'(OCT_MAX)));

  assert_small_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (map_en && small_sel) |-> (base_angle <= phase_t'(SMALL_MAX)));

endmodule

bind phase_octant_calc phase_calc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .phase_valid_o (phase_valid_o),
  .undef_o       (undef_o),
  .phase_o       (phase_o),
  .accept        (accept),
  .map_en        (map_en),
  .small_sel     (small_sel),
  .base_angle    (base_angle)
);

// File: tb/phase_octant_calc_tb.sv
`timescale 1ns/1ps
module phase_octant_calc_tb;

  localparam int  SUM_W    = 24;
  localparam int  TURN     = 4096;
  localparam int  LAT_NZ   = 14;
  localparam int  LAT_ZERO = 2;
  localparam real TWO_PI   = 6.283185307179586;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    start = 1'b0;
  logic signed [SUM_W-1:0] dc_c = '0;
  logic signed [SUM_W-1:0] dc_s = '0;
  logic                    busy;
  logic                    valid;
  logic [11:0]             phase;
  logic                    undef;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  phase_octant_calc #(.SUM_W(SUM_W)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .dc_cos_i      (dc_c),
    .dc_sin_i      (dc_s),
    .busy_o        (busy),
    .phase_valid_o (valid),
    .phase_o       (phase),
    .undef_o       (undef)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ideal_phase(input longint c, input longint s);
    real a;
    int  e;
    a = $atan2(real'(s), real'(c));
    if (a < 0.0) a = a + TWO_PI;
    e = int'(a / TWO_PI * real'(TURN));
    if (e >= TURN) e = e - TURN;
    return e;
  endfunction

  function automatic int circ_err(input int a, input int b);
    int d;
    d = a - b;
    while (d > TURN / 2) d = d - TURN;
    while (d < -TURN / 2) d = d + TURN;
    return (d < 0) ? -d : d;
  endfunction

  task automatic launch(input longint c, input longint s);
    @(negedge clk);
    dc_c  = SUM_W'(c);
    dc_s  = SUM_W'(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // lat counts rising edges since the one that sampled start (that one is 1)
  task automatic await(inout int lat);
    while (!valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic measure(input longint c, input longint s, input string req,
                         input int tol);
    int lat;
    int exp;
    launch(c, s);
    lat = 1;
    await(lat);
    exp = ideal_phase(c, s);
    check(valid == 1'b1, req, "valid seen", longint'(valid), 1);
    check(lat == LAT_NZ, "R2", "latency", lat, LAT_NZ);
    check(undef == 1'b0, "R4", "undef clear", longint'(undef), 0);
    check(circ_err(int'(phase), exp) <= tol, req, "phase", longint'(phase), exp);
  endtask

  task automatic t_reset_state;
    repeat (3) @(negedge clk);
    check(!busy && !valid && !undef && phase == 0, "R1", "outputs in reset",
          {busy, valid, undef, phase}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !valid && !undef && phase == 0, "R1", "outputs after reset",
          {busy, valid, undef, phase}, 0);
  endtask

  task automatic t_axes_R10;
    measure(1000, 0, "R10", 0);
    measure(0, 1000, "R10", 0);
    measure(-1000, 0, "R10", 0);
    measure(0, -1000, "R10", 0);
  endtask

  task automatic t_wide_octants_R6;
    measure(1000, 300, "R6", 3);
    measure(1000, -300, "R6", 3);
    measure(-1000, 300, "R6", 3);
    measure(-1000, -300, "R6", 3);
  endtask

  task automatic t_narrow_octants_R7;
    measure(300, 1000, "R7", 3);
    measure(300, -1000, "R7", 3);
    measure(-300, 1000, "R7", 3);
    measure(-300, -1000, "R7", 3);
  endtask

  task automatic t_equal_R8;
    measure(5000, 5000, "R8", 3);
    measure(-5000, 5000, "R8", 3);
    measure(5000, -5000, "R8", 3);
  endtask

  task automatic t_small_R9;
    measure(100000, 2000, "R9", 1);
    measure(-100000, 1000, "R9", 1);
    measure(3000, -200000, "R9", 1);
    measure(40000, 1240, "R9", 2);
  endtask

  task automatic t_sweep_R5;
    for (int k = 0; k < 48; k++) begin
      real    a;
      longint c;
      longint s;
      a = TWO_PI * (real'(k) + 0.37) / 48.0;
      c = longint'($rtoi($cos(a) * 3000000.0));
      s = longint'($rtoi($sin(a) * 3000000.0));
      measure(c, s, "R5", 3);
    end
  endtask

  task automatic t_zero_R4;
    int lat;
    measure(-700, 200, "R5", 3);
    launch(0, 0);
    lat = 1;
    await(lat);
    check(lat == LAT_ZERO, "R4", "zero latency", lat, LAT_ZERO);
    check(undef == 1'b1, "R4", "undef set", longint'(undef), 1);
    check(phase == 0, "R4", "zero phase", longint'(phase), 0);
    measure(200, 700, "R4", 3);
  endtask

  task automatic t_ignore_R3;
    int lat;
    int exp;
    launch(1000, 300);
    lat = 1;
    repeat (3) begin
      @(negedge clk);
      lat++;
    end
    dc_c  = -50;
    dc_s  = -900;
    start = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    await(lat);
    exp = ideal_phase(1000, 300);
    check(lat == LAT_NZ, "R3", "latency from first start", lat, LAT_NZ);
    check(circ_err(int'(phase), exp) <= 3, "R3", "first operands kept",
          longint'(phase), exp);
    repeat (LAT_NZ + 2) @(negedge clk);
    check(!busy && !valid, "R3", "no second result", {busy, valid}, 0);
  endtask

  task automatic t_hold_R11;
    logic [11:0] held;
    measure(-800, -1500, "R7", 3);
    held = phase;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(valid == 1'b0, "R11", "valid one cycle", longint'(valid), 0);
      check(phase == held, "R11", "phase held", longint'(phase), longint'(held));
    end
  endtask

  task automatic t_extreme_R12;
    measure(-(longint'(1) << (SUM_W - 1)), -(longint'(1) << (SUM_W - 1)), "R12", 3);
    measure((longint'(1) << (SUM_W - 1)) - 1, -(longint'(1) << (SUM_W - 1)), "R12", 3);
    measure(-(longint'(1) << (SUM_W - 1)), 1, "R12", 3);
  endtask

  initial begin
    t_reset_state();
    t_axes_R10();
    t_wide_octants_R6();
    t_narrow_octants_R7();
    t_equal_R8();
    t_small_R9();
    t_zero_R4();
    t_ignore_R3();
    t_hold_R11();
    t_extreme_R12();
    t_sweep_R5();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule